// File: doc/BRIEF.md
# Power-Mode Control Register and Sequencer

This block holds one 8-bit control register on a simple register bus and drives a three-state power-mode sequencer from it. Two bits in the register are live. One chooses which low-power state a sleep strobe enters: a light sleep or a deeper software standby. The other decides whether a group of controlled output pins is floated while the chip sits in software standby. The remaining six bits are fixed read-only constants.

Both live bits are guarded by a watchdog-enable status input. While that input is high, a write cannot raise either bit. A write can still clear either bit at any time. The register is loaded only by the synchronous power-on reset. Entering and leaving a low-power state leaves its contents as they were. Register writes are taken only while the sequencer is running. A wake input brings the sequencer back to run.

Top module: `pwrmode_ctrl`

## Requirements
- R1: After the synchronous reset the register reads 0x1F, `mode` is 2'b00 (run) and `pins_hiz` is 0.
- R2: Bit 5 always reads 0 and bits 4..0 always read 1, so the low six bits of a read are 6'h1F whatever was written.
- R3: Bit 7 (deep-standby select) and bit 6 (pin-float select) take a written 1 when `wdog_on` is 0. While `wdog_on` is 1, a write of 1 to a bit that holds 0 leaves that bit at 0.
- R4: A write of 0 to bit 7 or bit 6 clears that bit whatever `wdog_on` is. A bit that already holds 1 stays at 1 when 1 is written while `wdog_on` is 1.
- R5: A `sleep_req` pulse in run moves `mode` on the next clock edge to 2'b01 (sleep) when bit 7 is 0, or to 2'b10 (standby) when bit 7 is 1. `mode` never takes the value 2'b11.
- R6: `wake` in sleep or standby returns `mode` to 2'b00 on the next edge. Entering and leaving either low-power state does not change the register contents.
- R7: `pins_hiz` is 1 only while `mode` is 2'b10 and bit 6 is 1. It falls on the same edge at which `mode` leaves 2'b10.
- R8: Register writes made while `mode` is not 2'b00 are ignored.
- R9: `rd_data` shows the register value while `rd_en` is 1 and is 8'h00 while `rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 8 | Register read data, zero when not reading |
| sleep_req | input | 1 | One-cycle sleep instruction strobe |
| wdog_on | input | 1 | Watchdog enabled status; locks setting of bits 7 and 6 |
| wake | input | 1 | Wake event returning to run |
| mode | output | 2 | Current power mode: 00 run, 01 sleep, 10 standby |
| pins_hiz | output | 1 | Float enable for controlled pins |

## Verification
The bench writes the live bits under the lock in every combination of current value and written value. A design that locks the whole write would wrongly refuse a clear. A design that lets a set through would enter standby or float the pins while the watchdog runs. It writes during sleep and during standby, then reads back after wake. A design that takes those writes, or that reloads the register on a mode change, would return a changed value. It samples `pins_hiz` in sleep with the float bit set, in standby with the float bit clear, and on the cycle after wake. A registered or poorly gated float enable would show up as a stray cycle of floated pins.

// File: rtl/pwrmode_pkg.sv
package pwrmode_pkg;

    localparam int REG_W     = 8;
    localparam int MODE_W    = 2;
    localparam int DEEP_BIT  = 7;
    localparam int FLOAT_BIT = 6;
    // constant part of the register: bit 5 low, bits 4..0 high
    localparam logic [REG_W-1:0] FIXED_VAL = 8'h1F;

    typedef enum logic [MODE_W-1:0] {
        PM_RUN  = 2'b00,
        PM_DOZE = 2'b01,
        PM_DEEP = 2'b10
    } pm_state_e;

    typedef struct packed {
        logic deep_sel;
        logic float_sel;
    } ctl_bits_t;

    localparam ctl_bits_t CTL_RESET = '{deep_sel: 1'b0, float_sel: 1'b0};

    // a bit may drop at any time; it may only rise while unlocked
    function automatic logic guarded_bit(logic cur, logic req, logic lock);
        return req & (cur | ~lock);
    endfunction

    function automatic ctl_bits_t apply_write(ctl_bits_t cur,
                                              logic [REG_W-1:0] d,
                                              logic lock);
        ctl_bits_t nxt;
        nxt.deep_sel  = guarded_bit(cur.deep_sel,  d[DEEP_BIT],  lock);
        nxt.float_sel = guarded_bit(cur.float_sel, d[FLOAT_BIT], lock);
        return nxt;
    endfunction

    function automatic logic [REG_W-1:0] compose(ctl_bits_t c);
        logic [REG_W-1:0] v;
        v            = FIXED_VAL;
        v[DEEP_BIT]  = c.deep_sel;
        v[FLOAT_BIT] = c.float_sel;
        return v;
    endfunction

endpackage

// File: rtl/pm_ctl_reg.sv
module pm_ctl_reg
    import pwrmode_pkg::*;
#(
    parameter int DW = REG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_stb,
    input  logic          wr_allow,
    input  logic          lock,
    input  logic [DW-1:0] wr_data,
    output ctl_bits_t     ctl_q
);

    ctl_bits_t ctl_d;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_stb && wr_allow) begin
            ctl_d = apply_write(ctl_q, wr_data, lock);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= CTL_RESET;
        end else begin
            ctl_q <= ctl_d;
        end
    end

endmodule

// File: rtl/pm_seq.sv
module pm_seq
    import pwrmode_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sleep_stb,
    input  logic      wake,
    input  logic      deep_sel,
    output pm_state_e state_q
);

    pm_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PM_RUN: begin
                if (sleep_stb) begin
                    state_d = deep_sel ? PM_DEEP : PM_DOZE;
                end
            end
            PM_DOZE, PM_DEEP: begin
                if (wake) begin
                    state_d = PM_RUN;
                end
            end
            default: state_d = PM_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PM_RUN;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/pm_out_stage.sv
module pm_out_stage
    import pwrmode_pkg::*;
#(
    parameter int DW = REG_W
) (
    input  pm_state_e     state,
    input  ctl_bits_t     ctl,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          pins_hiz
);

    // decoded straight from the state register, so it drops on the exit edge
    assign pins_hiz = (state == PM_DEEP) && ctl.float_sel;
    assign rd_data  = rd_en ? compose(ctl) : '0;

endmodule

// File: rtl/pwrmode_ctrl.sv
module pwrmode_ctrl
    import pwrmode_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_en,
    output logic [REG_W-1:0] rd_data,
    input  logic             sleep_req,
    input  logic             wdog_on,
    input  logic             wake,
    output logic [MODE_W-1:0] mode,
    output logic             pins_hiz
);

    ctl_bits_t ctl_q;
    pm_state_e state_q;
    logic      deep_q;
    logic      float_q;
    logic      in_run;

    assign in_run  = (state_q == PM_RUN);
    assign deep_q  = ctl_q.deep_sel;
    assign float_q = ctl_q.float_sel;
    assign mode    = state_q;

    pm_ctl_reg #(.DW(REG_W)) u_reg (
        .clk      (clk),
        .rst      (rst),
        .wr_stb   (wr_en),
        .wr_allow (in_run),
        .lock     (wdog_on),
        .wr_data  (wr_data),
        .ctl_q    (ctl_q)
    );

    pm_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .sleep_stb (sleep_req),
        .wake      (wake),
        .deep_sel  (deep_q),
        .state_q   (state_q)
    );

    pm_out_stage #(.DW(REG_W)) u_out (
        .state    (state_q),
        .ctl      (ctl_q),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .pins_hiz (pins_hiz)
    );

endmodule

// File: rtl/pwrmode_ctrl_chk.sv
module pwrmode_ctrl_chk
    import pwrmode_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              wdog_on,
    input logic              sleep_req,
    input logic              wake,
    input logic              rd_en,
    input logic [REG_W-1:0]  rd_data,
    input logic [MODE_W-1:0] mode,
    input logic              pins_hiz,
    input logic              deep_q,
    input logic              float_q
);

    AST_FIXED_BITS: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (rd_data[5:0] == 6'h1F));                                          // R2

    AST_DEEP_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wdog_on && !deep_q) |=> !deep_q);                                   // R3

    AST_FLOAT_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wdog_on && !float_q) |=> !float_q);                                 // R3

    AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_RUN && sleep_req) |=> (mode != PM_RUN));                          // R5

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        mode != 2'b11);                                                               // R5

    AST_WAKE_RETURN: assert property (@(posedge clk) disable iff (rst)
        (mode != PM_RUN && wake) |=> (mode == PM_RUN));                               // R6

    AST_HIZ_ONLY_DEEP: assert property (@(posedge clk) disable iff (rst)
        pins_hiz |-> (mode == PM_DEEP && float_q));                                   // R7

    AST_NO_WRITE_ASLEEP: assert property (@(posedge clk) disable iff (rst)
        (mode != PM_RUN) |=> ($stable(deep_q) && $stable(float_q)));                  // R8

    AST_IDLE_READ: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (rd_data == '0));                                                  // R9

endmodule

bind pwrmode_ctrl pwrmode_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wdog_on   (wdog_on),
    .sleep_req (sleep_req),
    .wake      (wake),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .mode      (mode),
    .pins_hiz  (pins_hiz),
    .deep_q    (deep_q),
    .float_q   (float_q)
);

// File: tb/tb_pwrmode_ctrl.sv
`timescale 1ns/1ps
module tb_pwrmode_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       sleep_req = 1'b0;
    logic       wdog_on = 1'b0;
    logic       wake = 1'b0;
    logic [1:0] mode;
    logic       pins_hiz;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    pwrmode_ctrl dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .sleep_req(sleep_req),
        .wdog_on(wdog_on), .wake(wake), .mode(mode), .pins_hiz(pins_hiz)
    );

    task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic reg_read_chk(string req, logic [7:0] exp);
        @(negedge clk);
        rd_en = 1'b1;
        #1;
        check(req, "read", rd_data, exp);
        rd_en = 1'b0;
    endtask

    task automatic pulse_sleep();
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk); sleep_req = 1'b0;
    endtask

    task automatic pulse_wake();
        @(negedge clk); wake = 1'b1;
        @(negedge clk); wake = 1'b0;
    endtask

    task automatic t_reset();
        reg_read_chk("R1", 8'h1F);
        check("R1", "mode", {6'd0, mode}, 8'h00);
        check("R1", "pins_hiz", {7'd0, pins_hiz}, 8'h00);
    endtask

    task automatic t_fixed_bits();
        wdog_on = 1'b0;
        reg_write(8'h20);
        reg_read_chk("R2", 8'h1F);
        reg_write(8'h00);
        reg_read_chk("R2", 8'h1F);
    endtask

    task automatic t_set_unlocked();
        wdog_on = 1'b0;
        reg_write(8'hC0);
        reg_read_chk("R3", 8'hDF);
        reg_write(8'h00);
        reg_read_chk("R4", 8'h1F);
    endtask

    task automatic t_set_locked();
        wdog_on = 1'b1;
        reg_write(8'hC0);
        reg_read_chk("R3", 8'h1F);
        reg_write(8'h80);
        reg_read_chk("R3", 8'h1F);
        reg_write(8'h40);
        reg_read_chk("R3", 8'h1F);
        wdog_on = 1'b0;
    endtask

    task automatic t_clear_locked();
        wdog_on = 1'b0;
        reg_write(8'hC0);
        wdog_on = 1'b1;
        reg_write(8'hC0);
        reg_read_chk("R4", 8'hDF);
        reg_write(8'h40);
        reg_read_chk("R4", 8'h5F);
        reg_write(8'h00);
        reg_read_chk("R4", 8'h1F);
        wdog_on = 1'b0;
    endtask

    task automatic t_doze();
        reg_write(8'h40);
        pulse_sleep();
        check("R5", "mode doze", {6'd0, mode}, 8'h01);
        check("R7", "hiz in doze", {7'd0, pins_hiz}, 8'h00);
        reg_write(8'hC0);
        check("R8", "mode still doze", {6'd0, mode}, 8'h01);
        pulse_wake();
        check("R6", "mode after wake", {6'd0, mode}, 8'h00);
        reg_read_chk("R8", 8'h5F);
    endtask

    task automatic t_deep();
        reg_write(8'hC0);
        pulse_sleep();
        check("R5", "mode deep", {6'd0, mode}, 8'h02);
        check("R7", "hiz in deep", {7'd0, pins_hiz}, 8'h01);
        reg_write(8'h00);
        check("R7", "hiz held", {7'd0, pins_hiz}, 8'h01);
        pulse_wake();
        check("R6", "mode after wake", {6'd0, mode}, 8'h00);
        check("R7", "hiz after exit", {7'd0, pins_hiz}, 8'h00);
        reg_read_chk("R6", 8'hDF);
    endtask

    task automatic t_deep_no_float();
        reg_write(8'h80);
        pulse_sleep();
        check("R5", "mode deep", {6'd0, mode}, 8'h02);
        check("R7", "hiz without float", {7'd0, pins_hiz}, 8'h00);
        pulse_wake();
        check("R6", "mode after wake", {6'd0, mode}, 8'h00);
        reg_read_chk("R6", 8'h9F);
    endtask

    task automatic t_idle_read();
        @(negedge clk);
        rd_en = 1'b0;
        #1;
        check("R9", "idle read", rd_data, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fixed_bits();
        t_set_unlocked();
        t_set_locked();
        t_clear_locked();
        t_doze();
        t_deep();
        t_deep_no_float();
        t_idle_read();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule